// File: doc/BRIEF.md
# Three-Mode Local Interrupt Timer

A per-core timer that raises a single-cycle interrupt request carrying a programmed vector. It runs in one of three modes. One-shot mode counts a programmed number of bus-clock ticks down once. Periodic mode counts down, reloads and repeats. Deadline mode compares an absolute 64-bit deadline against a free-running timestamp input. Software reaches it through two ports: a 32-bit register port and a separate 64-bit deadline port.

The 32-bit port exposes four words:
- address 0: the control word, which holds the vector, the mask and the mode.
- address 1: the reload count.
- address 2: the live count.
- address 3: the prescale selector.

The countdown registers and the deadline register exclude each other by mode. A write to one set is dropped, and reads of it return zero, while the other mode is selected. Switching modes drops whatever was armed.

Top module: `tmr_top`

## Requirements
- R1: After reset the control word reads 0x0001_0000, which is vector 0, masked, one-shot mode. The reload count, live count and prescale selector read 0, and the deadline port reads 0.
- R2: The control word keeps only the vector (bits 7:0), the mask (bit 16) and the mode (bits 18:17). Bit 18 is dropped when `dl_cap` is low. While `sw_enable` is low, a stored control word always has bit 16 set.
- R3: A control-word write whose mode field differs from the current mode disarms both the countdown and the deadline. Mode codes are 00 one-shot, 01 periodic, 10 deadline and 11 reserved.
- R4: In one-shot mode, writing a nonzero reload count N arms the timer for N×D bus clocks, and exactly one pulse follows. D is set by the selector bits {3,1:0}: 000→2, 001→4, 010→8, 011→16, 100→32, 101→64, 110→128, 111→1. Writing N=0 stops the timer. The selector reads back with only bits 3, 1 and 0 kept.
- R5: While a countdown is armed, the live count reads (remaining bus clocks) >> log2(D). It equals N right after the load.
- R6: In periodic mode the timer fires every N×D bus clocks, raised to `MIN_PERIOD` when the product is smaller.
- R7: In deadline mode, writing a nonzero deadline arms the timer. It fires in the first cycle whose timestamp is ≥ the deadline, and the stored deadline then reads 0. Writing a deadline of 0 leaves the timer disarmed.
- R8: A deadline not greater than the current timestamp fires one cycle after the write.
- R9: In deadline mode, the live count reads 0 and reload-count writes are dropped. In the countdown modes, the deadline port reads 0 and deadline writes are dropped.
- R10: An expiry while bit 16 is set produces no pulse. An unmasked pulse carries the vector from bits 7:0 on `irq_vector`.
- R11: In the reserved mode neither the countdown nor the deadline ever arms.
- R12: A reload-count write to a running countdown restarts it from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_enable | input | 1 | Unit software enable; low forces the mask on control writes |
| dl_cap | input | 1 | Deadline capability; low makes mode bit 18 read-only zero |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| dl_we | input | 1 | Deadline write strobe |
| dl_wdata | input | 64 | Deadline write data |
| dl_rdata | output | 64 | Registered deadline read data |
| tsc | input | 64 | Free-running timestamp |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector delivered with the pulse |

## Verification
A countdown pulse becomes visible exactly P cycles after the clock edge that captured the reload write. The bench counts falling edges from that write and expects the first pulse at count P, where P is computed from N, D and the clamp. For a periodic timer it also expects the second pulse at count 2P.

A deadline pulse appears one edge after the comparing cycle, so the timestamp seen beside the pulse must equal the deadline plus one. An immediate deadline must pulse on the first falling edge after the write.

Register reads are registered, so each read value is taken one full cycle after the address is presented. Each live-count sample is compared with the remaining clock count from one edge earlier.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_ONESHOT  = 2'b00,
    MD_PERIODIC = 2'b01,
    MD_DEADLINE = 2'b10,
    MD_RSVD     = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LOAD = 2'd1;
  localparam logic [1:0] A_LIVE = 2'd2;
  localparam logic [1:0] A_PRE  = 2'd3;

  localparam int MASK_BIT = 16;
  localparam int MODE_LO  = 17;
  localparam int MODE_HI  = 18;

  // selector {b3,b1,b0} -> log2 of the divide ratio
  function automatic logic [2:0] pre_shift(input logic [2:0] code);
    return (code == 3'b111) ? 3'd0 : code + 3'd1;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_enable,
  input  logic             dl_cap,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] load_q,
  output logic [REG_W-1:0] pre_q,
  output tmr_mode_e        mode,
  output logic [2:0]       shift,
  output logic             mode_cancel,
  output logic             cd_load
);
  localparam logic [REG_W-1:0] KEEP_BASE = REG_W'(32'h0001_00FF);
  localparam logic [REG_W-1:0] KEEP_LO   = REG_W'(1) << MODE_LO;
  localparam logic [REG_W-1:0] KEEP_HI   = REG_W'(1) << MODE_HI;
  localparam logic [REG_W-1:0] PRE_KEEP  = REG_W'(4'hB);
  localparam logic [REG_W-1:0] CTRL_RST  = REG_W'(1) << MASK_BIT;

  logic [REG_W-1:0] keep;
  logic [REG_W-1:0] ctrl_new;
  logic             ctrl_wr;
  logic             load_wr;

  assign mode  = tmr_mode_e'(ctrl_q[MODE_HI:MODE_LO]);
  assign shift = pre_shift({pre_q[3], pre_q[1:0]});

  always_comb begin
    keep     = KEEP_BASE | KEEP_LO | (dl_cap ? KEEP_HI : '0);
    ctrl_new = reg_wdata & keep;
    if (!sw_enable) ctrl_new[MASK_BIT] = 1'b1;
  end

  assign ctrl_wr     = reg_we && (reg_addr == A_CTRL);
  assign load_wr     = reg_we && (reg_addr == A_LOAD) && (mode != MD_DEADLINE);
  assign mode_cancel = ctrl_wr && (ctrl_new[MODE_HI:MODE_LO] != ctrl_q[MODE_HI:MODE_LO]);
  assign cd_load     = load_wr && ((mode == MD_ONESHOT) || (mode == MD_PERIODIC));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      load_q <= '0;
      pre_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_new;
      if (load_wr) load_q <= reg_wdata;
      if (reg_we && reg_addr == A_PRE) pre_q <= reg_wdata & PRE_KEEP;
    end
  end
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
  parameter int CNT_W      = 32,
  parameter int MIN_PERIOD = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cancel,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [2:0]       shift,
  input  logic             periodic,
  output logic             fire,
  output logic             armed,
  output logic [CNT_W-1:0] live_cnt
);
  localparam int REM_W = CNT_W + 7;
  localparam logic [REM_W-1:0] MIN_P = REM_W'(MIN_PERIOD);

  logic [REM_W-1:0] rem_q, reload_q, raw, eff;
  logic [2:0]       sh_q;
  logic             per_q;

  assign raw  = REM_W'(load_cnt) << shift;
  assign eff  = (periodic && raw < MIN_P) ? MIN_P : raw;
  assign fire = armed && (rem_q == REM_W'(1));
  assign live_cnt = armed ? CNT_W'(rem_q >> sh_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      rem_q    <= '0;
      reload_q <= '0;
      sh_q     <= '0;
      per_q    <= 1'b0;
    end else if (cancel) begin
      armed <= 1'b0;
      rem_q <= '0;
    end else if (load) begin
      if (load_cnt == '0) begin
        armed <= 1'b0;
        rem_q <= '0;
      end else begin
        armed    <= 1'b1;
        rem_q    <= eff;
        reload_q <= eff;
        sh_q     <= shift;
        per_q    <= periodic;
      end
    end else if (armed) begin
      if (fire) begin
        if (per_q) rem_q <= reload_q;
        else begin
          armed <= 1'b0;
          rem_q <= '0;
        end
      end else begin
        rem_q <= rem_q - REM_W'(1);
      end
    end
  end
endmodule

// File: rtl/tmr_deadline.sv
module tmr_deadline #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cancel,
  input  logic            wr,
  input  logic [TS_W-1:0] wdata,
  input  logic [TS_W-1:0] tsc,
  output logic            fire,
  output logic            armed,
  output logic [TS_W-1:0] dl_q
);
  assign fire = armed && (tsc >= dl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      dl_q  <= '0;
    end else if (cancel) begin
      armed <= 1'b0;
    end else if (wr) begin
      dl_q  <= wdata;
      armed <= (wdata != '0);
    end else if (fire) begin
      armed <= 1'b0;
      dl_q  <= '0;
    end
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int CNT_W      = 32,
  parameter int TS_W       = 64,
  parameter int VEC_W      = 8,
  parameter int MIN_PERIOD = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_enable,
  input  logic             dl_cap,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             dl_we,
  input  logic [TS_W-1:0]  dl_wdata,
  output logic [TS_W-1:0]  dl_rdata,
  input  logic [TS_W-1:0]  tsc,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector
);
  logic [REG_W-1:0] ctrl_q, load_q, pre_q;
  tmr_mode_e        mode;
  logic [2:0]       shift;
  logic             mode_cancel, cd_load;
  logic             cd_fire, cd_armed, dl_fire, dl_armed, dl_wr;
  logic [CNT_W-1:0] live_cnt;
  logic [TS_W-1:0]  dl_q;
  logic             masked;
  logic [1:0]       mode_bits;

  assign masked    = ctrl_q[MASK_BIT];
  assign mode_bits = ctrl_q[MODE_HI:MODE_LO];
  assign dl_wr     = dl_we && (mode == MD_DEADLINE);

  tmr_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .sw_enable(sw_enable), .dl_cap(dl_cap),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ctrl_q(ctrl_q), .load_q(load_q), .pre_q(pre_q), .mode(mode),
    .shift(shift), .mode_cancel(mode_cancel), .cd_load(cd_load)
  );

  tmr_countdown #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_cd (
    .clk(clk), .rst(rst), .cancel(mode_cancel), .load(cd_load),
    .load_cnt(CNT_W'(reg_wdata)), .shift(shift),
    .periodic(mode == MD_PERIODIC), .fire(cd_fire), .armed(cd_armed),
    .live_cnt(live_cnt)
  );

  tmr_deadline #(.TS_W(TS_W)) u_dl (
    .clk(clk), .rst(rst), .cancel(mode_cancel), .wr(dl_wr),
    .wdata(dl_wdata), .tsc(tsc), .fire(dl_fire), .armed(dl_armed),
    .dl_q(dl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
      reg_rdata  <= '0;
      dl_rdata   <= '0;
    end else begin
      irq_pulse <= (cd_fire || dl_fire) && !masked;
      if ((cd_fire || dl_fire) && !masked) irq_vector <= ctrl_q[VEC_W-1:0];
      unique case (reg_addr)
        A_CTRL:  reg_rdata <= ctrl_q;
        A_LOAD:  reg_rdata <= load_q;
        A_LIVE:  reg_rdata <= (mode == MD_DEADLINE) ? '0 : REG_W'(live_cnt);
        default: reg_rdata <= pre_q;
      endcase
      dl_rdata <= (mode == MD_DEADLINE) ? dl_q : '0;
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int TS_W = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_pulse,
  input logic            masked,
  input logic [1:0]      mode_bits,
  input logic            mode_cancel,
  input logic            cd_load,
  input logic            cd_fire,
  input logic            cd_armed,
  input logic            dl_fire,
  input logic            dl_wr,
  input logic            dl_armed,
  input logic [TS_W-1:0] dl_rdata
);
  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> !$past(masked));

  // R3
  mode_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    mode_cancel |=> (!cd_armed && !dl_armed));

  // R11
  rsvd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_bits == 2'b11) |-> (!cd_armed && !dl_armed));

  // R9
  dl_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_bits != 2'b10) |=> (dl_rdata == '0));

  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (cd_fire && mode_bits == 2'b01 && !mode_cancel && !cd_load) |=> cd_armed);

  // R7
  dl_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (dl_fire && !mode_cancel && !dl_wr) |=> !dl_armed);
endmodule

bind tmr_top tmr_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst(rst), .irq_pulse(irq_pulse), .masked(masked),
  .mode_bits(mode_bits), .mode_cancel(mode_cancel), .cd_load(cd_load),
  .cd_fire(cd_fire), .cd_armed(cd_armed), .dl_fire(dl_fire),
  .dl_wr(dl_wr), .dl_armed(dl_armed), .dl_rdata(dl_rdata)
);

// File: tb/tb_tmr_top.sv
module tb_tmr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_enable = 1'b1;
  logic        dl_cap = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dl_we = 1'b0;
  logic [63:0] dl_wdata = '0;
  logic [63:0] dl_rdata;
  logic [63:0] tsc = '0;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) tsc <= rst ? 64'd1000 : tsc + 64'd1;

  tmr_top dut (
    .clk(clk), .rst(rst), .sw_enable(sw_enable), .dl_cap(dl_cap),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dl_we(dl_we), .dl_wdata(dl_wdata),
    .dl_rdata(dl_rdata), .tsc(tsc), .irq_pulse(irq_pulse),
    .irq_vector(irq_vector)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wr_dl(input logic [63:0] d);
    @(negedge clk);
    dl_we = 1'b1; dl_wdata = d;
    @(negedge clk);
    dl_we = 1'b0;
  endtask

  task automatic watch(input int n, output int f1, output int f2, output int cnt,
                       output logic [7:0] v1, output logic [63:0] t1);
    f1 = 0; f2 = 0; cnt = 0; v1 = '0; t1 = '0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (irq_pulse) begin
        cnt++;
        if (f1 == 0) begin f1 = k; v1 = irq_vector; t1 = tsc; end
        else if (f2 == 0) f2 = k;
      end
    end
  endtask

  function automatic int ratio(input int code);
    return (code == 7) ? 1 : (2 << code);
  endfunction

  function automatic logic [31:0] pre_word(input int code);
    logic [2:0] c;
    c = 3'(code);
    return {28'd0, c[2], 1'b0, c[1:0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  v1;
    logic [63:0] t1, d;
    int f1, f2, cnt, p;
    int inits [3];
    inits = '{1, 3, 6};

    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd_reg(2'd0, rd); check("R1 ctrl", rd, 32'h0001_0000);
    rd_reg(2'd1, rd); check("R1 load", rd, 0);
    rd_reg(2'd2, rd); check("R1 live", rd, 0);
    rd_reg(2'd3, rd); check("R1 pre", rd, 0);
    check("R1 deadline", dl_rdata, 0);

    // R9 deadline write dropped in one-shot mode
    wr_dl(64'h99);

    // R2 field retention
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, rd); check("R2 keep", rd, 32'h0007_00FF);
    dl_cap = 1'b0;
    wr_reg(2'd0, 32'h0004_0055);
    rd_reg(2'd0, rd); check("R2 no_cap", rd, 32'h0000_0055);
    dl_cap = 1'b1; sw_enable = 1'b0;
    wr_reg(2'd0, 32'h0000_0042);
    rd_reg(2'd0, rd); check("R2 sw_off", rd, 32'h0001_0042);
    sw_enable = 1'b1;
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd_reg(2'd3, rd); check("R4 pre_keep", rd, 32'h0000_000B);

    // R4 one-shot sweep over all prescale codes
    wr_reg(2'd0, 32'h0000_0020);
    for (int c = 0; c < 8; c++) begin
      wr_reg(2'd3, pre_word(c));
      for (int i = 0; i < 3; i++) begin
        p = inits[i] * ratio(c);
        wr_reg(2'd1, 32'(inits[i]));
        watch(p + 10, f1, f2, cnt, v1, t1);
        check("R4 first", 64'(f1), 64'(p));
        check("R4 count", 64'(cnt), 1);
        check("R10 vector", 64'(v1), 64'h20);
      end
    end
    wr_reg(2'd1, 0);
    watch(50, f1, f2, cnt, v1, t1);
    check("R4 zero_stops", 64'(cnt), 0);

    // R5 live count, ratio 2, N=10
    wr_reg(2'd3, pre_word(0));
    wr_reg(2'd1, 10);
    reg_addr = 2'd2;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R5 live", reg_rdata, 32'((21 - k) >> 1));
    end
    wr_reg(2'd1, 0);

    // R12 restart
    wr_reg(2'd1, 10);
    repeat (8) @(negedge clk);
    wr_reg(2'd1, 5);
    watch(40, f1, f2, cnt, v1, t1);
    check("R12 first", 64'(f1), 10);
    check("R12 count", 64'(cnt), 1);

    // R6 periodic with clamp
    wr_reg(2'd0, 32'h0002_0021);
    begin
      int pc [4]; int pn [4]; int pe [4];
      pc = '{1, 0, 0, 7}; pn = '{10, 3, 8, 20}; pe = '{40, 16, 16, 20};
      for (int j = 0; j < 4; j++) begin
        wr_reg(2'd3, pre_word(pc[j]));
        wr_reg(2'd1, 32'(pn[j]));
        watch(2 * pe[j] + 3, f1, f2, cnt, v1, t1);
        check("R6 first", 64'(f1), 64'(pe[j]));
        check("R6 second", 64'(f2), 64'(2 * pe[j]));
        check("R6 vector", 64'(v1), 64'h21);
      end
    end

    // R10 mask suppresses, unmask resumes with new vector
    wr_reg(2'd0, 32'h0003_0021);
    watch(60, f1, f2, cnt, v1, t1);
    check("R10 masked", 64'(cnt), 0);
    wr_reg(2'd0, 32'h0002_0033);
    watch(25, f1, f2, cnt, v1, t1);
    check("R10 resumed", 64'(cnt > 0), 1);
    check("R10 new_vector", 64'(v1), 64'h33);

    // R3 mode change cancels countdown
    wr_reg(2'd0, 32'h0000_0020);
    wr_reg(2'd3, pre_word(0));
    wr_reg(2'd1, 20);
    repeat (5) @(negedge clk);
    wr_reg(2'd0, 32'h0004_0020);
    watch(60, f1, f2, cnt, v1, t1);
    check("R3 cd_cancel", 64'(cnt), 0);

    // R9 deadline mode hides the countdown set
    rd_reg(2'd2, rd); check("R9 live_zero", rd, 0);
    wr_reg(2'd1, 32'h1234);
    rd_reg(2'd1, rd); check("R9 load_kept", rd, 20);
    check("R9 dl_dropped", dl_rdata, 0);

    // R7 future deadline
    d = tsc + 64'd40;
    wr_dl(d);
    @(negedge clk);
    check("R7 stored", dl_rdata, d);
    watch(60, f1, f2, cnt, v1, t1);
    check("R7 count", 64'(cnt), 1);
    check("R7 fire_ts", t1, d + 64'd1);
    check("R7 cleared", dl_rdata, 0);
    wr_dl(64'd0);
    watch(20, f1, f2, cnt, v1, t1);
    check("R7 zero", 64'(cnt), 0);

    // R8 past deadline
    wr_dl(64'd5);
    watch(5, f1, f2, cnt, v1, t1);
    check("R8 immediate", 64'(f1), 1);
    check("R8 count", 64'(cnt), 1);

    // R3 mode change cancels deadline
    wr_dl(tsc + 64'd50);
    wr_reg(2'd0, 32'h0000_0020);
    wr_reg(2'd0, 32'h0004_0020);
    watch(80, f1, f2, cnt, v1, t1);
    check("R3 dl_cancel", 64'(cnt), 0);

    // R11 reserved mode
    wr_reg(2'd0, 32'h0006_0020);
    wr_reg(2'd3, pre_word(7));
    wr_reg(2'd1, 2);
    watch(30, f1, f2, cnt, v1, t1);
    check("R11 no_cd", 64'(cnt), 0);
    rd_reg(2'd2, rd); check("R11 live", rd, 0);
    wr_dl(64'd3);
    watch(10, f1, f2, cnt, v1, t1);
    check("R11 no_dl", 64'(cnt), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule